// File: doc/BRIEF.md
# Multi-Channel DAC Register Bank

This block holds the digital state behind an eight-channel converter. It takes committed words, each a 4-bit address with a 12-bit data field, from an upstream serial receiver. From them it keeps a 10-bit code for every channel, two configuration registers and a preset value. Every channel has two stages. An input register takes the written code. An output latch feeds the converter and follows the input register whenever the active-low load input is low. Holding load low makes a write visible at once. Holding it high lets software stage all eight channels and then release them together.

Four pair addresses write a code to the even channel of a pair and the bitwise inverse to the odd channel, which gives a differential output with a single word. An optional two's-complement coding mode turns signed input into the offset-binary codes the converter uses. An asynchronous active-low preset input forces every channel output to the preset register's value. This override acts at the outputs only. The latches keep their contents and reappear unchanged when preset is released.

Top module: `dac_regbank`

## Requirements
- R1: After a synchronous reset, every channel output is 0 while preset is high, and all control outputs (power-down, speed, daisy-chain enable, reference select) are 0. The preset register is also cleared, so a preset applied before any write to address 10 shows 0 on every channel.
- R2: A write to address n (0 to 7) stores data bits 11:2 as the code of channel n. Channel 0 is the lowest ten bits of `ch_code`. Data bits 1:0 have no effect on any output.
- R3: When `load_n` is low at the clock edge that takes a channel write, the channel output shows the new code after that same edge.
- R4: While `load_n` is high, channel outputs do not change. The first clock edge with `load_n` low copies every input register to its output.
- R5: A write to address 8 sets `global_pd` from bit 4, `chain_en` from bit 3, `ref_sel` from bits 2:1 and the input coding from bit 0 (0 straight binary, 1 two's complement).
- R6: A write to address 9 sets `pair_pd[k]` from bit 4+k and `pair_fast[k]` from bit k. Pair k is channels 2k and 2k+1.
- R7: While `preset_n` is low, every channel output equals the preset register, which is written at address 10 from data bits 11:2. The override is combinational and needs no clock edge.
- R8: Releasing `preset_n` restores the latched channel codes, including codes loaded while preset was low.
- R9: A write to address 11 changes no output and no stored register.
- R10: A write to address 12+k stores the code in channel 2k and its bitwise inverse in channel 2k+1. For example, code 1023 gives 1023 and 0.
- R11: In two's-complement mode, the MSB of the 10-bit field is inverted before storing. This applies to channel, preset and pair writes, and the pair inverse is taken after the conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Committed-word strobe, one cycle per word |
| wr_addr | input | 4 | Register address of the word |
| wr_data | input | 12 | Data field of the word |
| load_n | input | 1 | Active-low transfer from input registers to output latches |
| preset_n | input | 1 | Asynchronous active-low preset override |
| ch_code | output | 80 | Eight 10-bit channel codes, channel 0 in bits 9:0 |
| pair_pd | output | 4 | Per-pair power-down, bit 0 = channels 0/1 |
| pair_fast | output | 4 | Per-pair fast settling select |
| global_pd | output | 1 | Whole-device power-down |
| chain_en | output | 1 | Daisy-chain output enable |
| ref_sel | output | 2 | Reference select: 00 and 11 external, 01 low internal, 10 high internal |

## Verification
The ports cannot observe the input registers directly. The hardest state to expose is a staged value that differs from the latched one, or an override that must leave the latches alone. The stimulus reaches it by writing with `load_n` held high, then writing the reserved address, then asserting `preset_n` and writing more channels under the override. Each of those stages is checked at the outputs. Only afterwards does a single load cycle or the preset release reveal what the hidden registers held. The coding mode is swept with channel, pair and preset writes, so that the order of conversion and inversion shows at the outputs.

// File: rtl/dac_rb_pkg.sv
package dac_rb_pkg;

    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 12;
    localparam int CODE_W    = 10;
    localparam int NUM_CH    = 8;
    localparam int NUM_PAIRS = NUM_CH / 2;
    localparam int IDX_W     = $clog2(NUM_CH);
    localparam int CODE_LSB  = DATA_W - CODE_W;
    localparam int CFG0_W    = 5;
    localparam int CFG1_W    = 2 * NUM_PAIRS;

    localparam logic [ADDR_W-1:0] A_CTRL0  = ADDR_W'(NUM_CH);
    localparam logic [ADDR_W-1:0] A_CTRL1  = ADDR_W'(NUM_CH + 1);
    localparam logic [ADDR_W-1:0] A_PRESET = ADDR_W'(NUM_CH + 2);
    localparam logic [ADDR_W-1:0] A_PAIR0  = ADDR_W'(NUM_CH + 4);

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CHAN,
        OP_CTRL0,
        OP_CTRL1,
        OP_PRESET,
        OP_PAIR
    } op_e;

    // bit order matches the data field: 4 pd, 3 chain, 2:1 ref, 0 coding
    typedef struct packed {
        logic       gpd;
        logic       chain;
        logic [1:0] ref_sel;
        logic       twos;
    } cfg0_t;

    typedef struct packed {
        logic [NUM_PAIRS-1:0] pd;
        logic [NUM_PAIRS-1:0] fast;
    } cfg1_t;

    typedef struct packed {
        op_e              op;
        logic [IDX_W-1:0] idx;
        code_t            code;
    } wr_cmd_t;

    function automatic code_t fmt_code(input code_t raw, input logic twos);
        code_t c;
        c = raw;
        if (twos) c[CODE_W-1] = ~c[CODE_W-1];
        return c;
    endfunction

endpackage

// File: rtl/dac_rb_decode.sv
module dac_rb_decode
    import dac_rb_pkg::*;
(
    input  logic                wr_valid,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  code_t               raw_code,
    input  logic                twos,
    output wr_cmd_t             cmd
);

    always_comb begin
        cmd.op   = OP_NONE;
        cmd.idx  = '0;
        cmd.code = fmt_code(raw_code, twos);
        if (wr_valid) begin
            if (wr_addr < ADDR_W'(NUM_CH)) begin
                cmd.op  = OP_CHAN;
                cmd.idx = wr_addr[IDX_W-1:0];
            end else if (wr_addr == A_CTRL0) begin
                cmd.op = OP_CTRL0;
            end else if (wr_addr == A_CTRL1) begin
                cmd.op = OP_CTRL1;
            end else if (wr_addr == A_PRESET) begin
                cmd.op = OP_PRESET;
            end else if (wr_addr >= A_PAIR0) begin
                cmd.op  = OP_PAIR;
                cmd.idx = IDX_W'((wr_addr - A_PAIR0) << 1);
            end
        end
    end

endmodule

// File: rtl/dac_rb_chan.sv
module dac_rb_chan
    import dac_rb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  code_t wr_code,
    input  logic  load_n,
    output code_t out_q
);

    code_t in_q;
    code_t in_d;

    assign in_d = wr_en ? wr_code : in_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            out_q <= '0;
        end else begin
            in_q <= in_d;
            if (!load_n) out_q <= in_d;
        end
    end

endmodule

// File: rtl/dac_rb_cfg.sv
module dac_rb_cfg
    import dac_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [CFG1_W-1:0] ctl_bits,
    input  code_t             code,
    output cfg0_t             cfg0_q,
    output cfg1_t             cfg1_q,
    output code_t             preset_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg0_q   <= '0;
            cfg1_q   <= '0;
            preset_q <= '0;
        end else begin
            case (op)
                OP_CTRL0:  cfg0_q   <= cfg0_t'(ctl_bits[CFG0_W-1:0]);
                OP_CTRL1:  cfg1_q   <= cfg1_t'(ctl_bits);
                OP_PRESET: preset_q <= code;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
    import dac_rb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_valid,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     load_n,
    input  logic                     preset_n,
    output logic [NUM_CH*CODE_W-1:0] ch_code,
    output logic [NUM_PAIRS-1:0]     pair_pd,
    output logic [NUM_PAIRS-1:0]     pair_fast,
    output logic                     global_pd,
    output logic                     chain_en,
    output logic [1:0]               ref_sel
);

    wr_cmd_t cmd;
    cfg0_t   cfg0;
    cfg1_t   cfg1;
    code_t   preset_val;

    dac_rb_decode u_dec (
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .raw_code (wr_data[DATA_W-1:CODE_LSB]),
        .twos     (cfg0.twos),
        .cmd      (cmd)
    );

    dac_rb_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .op       (cmd.op),
        .ctl_bits (wr_data[CFG1_W-1:0]),
        .code     (cmd.code),
        .cfg0_q   (cfg0),
        .cfg1_q   (cfg1),
        .preset_q (preset_val)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [IDX_W-1:0] EVEN_IDX = IDX_W'(i - (i % 2));
        logic  sel_chan;
        logic  sel_pair;
        code_t code_in;
        code_t latched;

        assign sel_chan = (cmd.op == OP_CHAN) && (cmd.idx == IDX_W'(i));
        assign sel_pair = (cmd.op == OP_PAIR) && (cmd.idx == EVEN_IDX);

        if (i % 2 == 1) begin : g_odd
            assign code_in = sel_pair ? ~cmd.code : cmd.code;
        end else begin : g_even
            assign code_in = cmd.code;
        end

        dac_rb_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (sel_chan | sel_pair),
            .wr_code (code_in),
            .load_n  (load_n),
            .out_q   (latched)
        );

        assign ch_code[i*CODE_W +: CODE_W] = preset_n ? latched : preset_val;
    end

    assign pair_pd   = cfg1.pd;
    assign pair_fast = cfg1.fast;
    assign global_pd = cfg0.gpd;
    assign chain_en  = cfg0.chain;
    assign ref_sel   = cfg0.ref_sel;

endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk
    import dac_rb_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_valid,
    input logic [ADDR_W-1:0]        wr_addr,
    input logic [DATA_W-1:0]        wr_data,
    input logic                     load_n,
    input logic                     preset_n,
    input logic [NUM_CH*CODE_W-1:0] ch_code,
    input logic [NUM_PAIRS-1:0]     pair_pd,
    input logic [NUM_PAIRS-1:0]     pair_fast,
    input logic                     global_pd,
    input logic                     chain_en,
    input logic [1:0]               ref_sel
);

    wire unused_low_bits = ^wr_data[CODE_LSB-1:0];

    // R1: first sample after reset is released shows cleared state
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!global_pd && !chain_en && ref_sel == 2'b00 &&
                        pair_pd == '0 && pair_fast == '0 &&
                        (!preset_n || ch_code == '0)));

    // R4: no load at an edge means latched codes unchanged afterwards
    a_r4_hold_unloaded: assert property (@(posedge clk) disable iff (rst)
        (load_n && preset_n) ##1 preset_n |-> $stable(ch_code));

    // R5: control register 0 fields
    a_r5_ctrl0_fields: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr == A_CTRL0) |=>
            (global_pd == $past(wr_data[4]) && chain_en == $past(wr_data[3]) &&
             ref_sel == $past(wr_data[2:1])));

    // R6: control register 1 fields
    a_r6_ctrl1_fields: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr == A_CTRL1) |=>
            (pair_pd == $past(wr_data[2*NUM_PAIRS-1:NUM_PAIRS]) &&
             pair_fast == $past(wr_data[NUM_PAIRS-1:0])));

    // R9: reserved address leaves control outputs alone
    a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr == ADDR_W'(NUM_CH + 3)) |=>
            $stable({pair_pd, pair_fast, global_pd, chain_en, ref_sel}));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan_chk
        // R2 R3: immediate write shows the low code bits of the data field
        a_r3_immediate_write: assert property (@(posedge clk) disable iff (rst)
            (wr_valid && wr_addr == ADDR_W'(i) && !load_n) |=>
                (!preset_n || ch_code[i*CODE_W +: CODE_W-1] ==
                              $past(wr_data[DATA_W-2:CODE_LSB])));

        if (i > 0) begin : g_same
            // R7: all outputs agree while preset is held
            a_r7_preset_uniform: assert property (@(posedge clk) disable iff (rst)
                !preset_n |-> ch_code[i*CODE_W +: CODE_W] == ch_code[CODE_W-1:0]);
        end
    end

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair_chk
        // R10: odd channel of a pair is the inverse of the even one
        a_r10_pair_complement: assert property (@(posedge clk) disable iff (rst)
            (wr_valid && wr_addr == ADDR_W'(NUM_CH + 4 + k) && !load_n) |=>
                (!preset_n || ch_code[(2*k+1)*CODE_W +: CODE_W] ==
                              ~ch_code[(2*k)*CODE_W +: CODE_W]));
    end

endmodule

bind dac_regbank dac_regbank_chk u_chk (.*);

// File: tb/sim_dac_regbank.sv
`timescale 1ns/1ps
module sim_dac_regbank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        load_n = 1'b1;
    logic        preset_n = 1'b1;
    logic [79:0] ch_code;
    logic [3:0]  pair_pd;
    logic [3:0]  pair_fast;
    logic        global_pd;
    logic        chain_en;
    logic [1:0]  ref_sel;

    int checks = 0;
    int errors = 0;

    logic [9:0] m_in  [0:7];
    logic [9:0] m_out [0:7];
    logic [9:0] m_pre;
    logic [4:0] m_c0;
    logic [7:0] m_c1;

    always #2.5 clk = ~clk;

    dac_regbank u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_n(load_n), .preset_n(preset_n),
        .ch_code(ch_code), .pair_pd(pair_pd), .pair_fast(pair_fast),
        .global_pd(global_pd), .chain_en(chain_en), .ref_sel(ref_sel)
    );

    task automatic model_load();
        if (!load_n) for (int c = 0; c < 8; c++) m_out[c] = m_in[c];
    endtask

    task automatic do_write(input logic [3:0] a, input logic [11:0] d);
        logic [9:0] code;
        code = d[11:2] ^ (m_c0[0] ? 10'h200 : 10'h000);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_valid = 1'b0;
        if (a < 4'd8) m_in[a[2:0]] = code;
        else if (a == 4'd8) m_c0 = d[4:0];
        else if (a == 4'd9) m_c1 = d[7:0];
        else if (a == 4'd10) m_pre = code;
        else if (a >= 4'd12) begin
            m_in[2*(a-12)]   = code;
            m_in[2*(a-12)+1] = ~code;
        end
        model_load();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            model_load();
        end
    endtask

    task automatic check_all(input string req);
        #1;
        for (int c = 0; c < 8; c++) begin
            logic [9:0] exp, got;
            exp = preset_n ? m_out[c] : m_pre;
            got = ch_code[c*10 +: 10];
            checks++;
            if (got !== exp) begin
                errors++;
                $display("FAIL %s ch%0d: got %0d expected %0d", req, c, got, exp);
            end
        end
        checks++;
        if ({global_pd, chain_en, ref_sel, pair_pd, pair_fast} !==
            {m_c0[4], m_c0[3], m_c0[2:1], m_c1[7:4], m_c1[3:0]}) begin
            errors++;
            $display("FAIL %s ctrl: got %h expected %h", req,
                {global_pd, chain_en, ref_sel, pair_pd, pair_fast},
                {m_c0[4], m_c0[3], m_c0[2:1], m_c1[7:4], m_c1[3:0]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 8; c++) begin m_in[c] = '0; m_out[c] = '0; end
        m_pre = '0; m_c0 = '0; m_c1 = '0;
        @(negedge clk);
        idle(3);
        rst = 1'b0;
        check_all("R1 reset");

        // R2 R3: immediate writes, sweep codes with junk in bits 1:0
        load_n = 1'b0;
        for (int c = 0; c < 8; c++) begin
            for (int i = 0; i < 6; i++) begin
                int v;
                v = (i == 0) ? 0 : (i == 1) ? 1023 : (c * 97 + i * 211) % 1024;
                do_write(4'(c), {10'(v), 2'(i + c)});
                check_all("R2 R3 write");
            end
        end

        // R7 preset before any preset write reads zero; R8 release
        preset_n = 1'b0;
        check_all("R7 preset unwritten");
        preset_n = 1'b1;
        check_all("R8 release");

        // R4 staged writes then a single load cycle
        load_n = 1'b1;
        for (int c = 0; c < 8; c++) begin
            do_write(4'(c), {10'(1000 - c * 77), 2'b11});
            check_all("R4 staged hold");
        end
        do_write(4'd11, 12'hABC);
        check_all("R9 reserved staged");
        load_n = 1'b0;
        idle(1);
        check_all("R4 load");

        // R9 reserved address with immediate load
        for (int i = 0; i < 4; i++) begin
            do_write(4'd11, 12'(i * 1013 + 5));
            check_all("R9 reserved");
        end

        // R10 pair writes
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 4; i++) begin
                int v;
                v = (i == 0) ? 1023 : (i == 1) ? 0 : (k * 301 + i * 157) % 1024;
                do_write(4'(12 + k), {10'(v), 2'b01});
                check_all("R10 pair");
            end
        end

        // R5 control register 0 full sweep
        for (int v = 0; v < 32; v++) begin
            do_write(4'd8, {7'h5A, 5'(v)});
            check_all("R5 ctrl0");
        end
        do_write(4'd8, 12'h000);
        // R6 control register 1 full sweep
        for (int v = 0; v < 256; v++) begin
            do_write(4'd9, {4'hC, 8'(v)});
            check_all("R6 ctrl1");
        end

        // R7 preset value sweep and combinational override
        for (int i = 0; i < 5; i++) begin
            do_write(4'd10, {10'(i * 255 + 3), 2'b10});
            preset_n = 1'b0;
            check_all("R7 preset");
            preset_n = 1'b1;
            check_all("R8 release");
        end
        // R8 writes under preset reappear on release
        preset_n = 1'b0;
        for (int c = 0; c < 8; c++) begin
            do_write(4'(c), {10'(c * 111 + 7), 2'b00});
            check_all("R7 preset during write");
        end
        preset_n = 1'b1;
        check_all("R8 release after writes");

        // R11 two's-complement coding on channel, pair and preset writes
        do_write(4'd8, 12'h001);
        check_all("R11 mode on");
        for (int c = 0; c < 8; c++) begin
            do_write(4'(c), {10'(c * 131), 2'b00});
            check_all("R11 channel");
        end
        for (int k = 0; k < 4; k++) begin
            do_write(4'(12 + k), {10'(k * 200 + 9), 2'b00});
            check_all("R11 pair");
        end
        do_write(4'd10, {10'h3FF, 2'b00});
        preset_n = 1'b0;
        check_all("R11 preset");
        preset_n = 1'b1;
        do_write(4'd8, 12'h000);
        do_write(4'd0, {10'h200, 2'b00});
        check_all("R11 mode off");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule